// File: doc/BRIEF.md
# Fractional Sample Strobe Generator

This block paces audio sample consumption from a single fast reference clock. Software picks two integers, a numerator N and a denominator, so that their ratio is the wanted sample period in reference cycles. It packs them into one configuration word. The block then emits a one-cycle strobe whose spacing averages exactly N divided by the denominator. Each strobe is therefore either the floor or the ceiling of that ratio away from the previous one.

Inside, an accumulator adds the denominator on every reference cycle. Whenever the running total reaches N, the block removes N from it and raises the strobe. The fractional remainder carries forward, so rounding error never builds up. Software finds the best rational pair for a target rate such as 44.1 kHz or 192 kHz. The block does not compute that pair. A write of the configuration word restarts the pattern from a clean accumulator.

Top module: `frac_strobe_gen`

## Requirements
- R1: After reset the strobe is low and the configuration readback is zero.
- R2: The configuration word carries N in bits 31:8 and the denominator-minus-one value M in bits 7:0, so the effective denominator is M+1 (M=255 means 256). The readback returns the last word written.
- R3: Number the cycles after a configuration write j = 1, 2, and so on. With D = M+1, the strobe is high in cycle j exactly when floor(j·D/N) exceeds floor((j−1)·D/N).
- R4: With a valid setting, any run of N consecutive cycles after a write contains exactly M+1 strobes.
- R5: A configuration write clears the accumulator and forces the strobe low in the cycle that follows it. The sequence then restarts at j = 1, even when the same value is written again.
- R6: When N is zero, the strobe stays low.
- R7: When N is less than M+1, the strobe stays low.
- R8: When N equals M+1, the strobe is high in every cycle after the write cycle.
- R9: When 2·(M+1) ≤ N, no two strobes fall in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write enable for the configuration word |
| cfg_wdata | input | 32 | Configuration word: N in 31:8, M in 7:0 |
| cfg_rdata | output | 32 | Current configuration word |
| strobe | output | 1 | One-cycle sample strobe |

## Verification
The bench goes after four kinds of setting:
- The boundary where N equals M+1. A comparison that used "greater than" instead of "at least" would never fire here, or would fire at half rate.
- Settings where N is below the denominator or is zero. A missing validity guard would leave the accumulator wrapping and strobing at random.
- The full 256 denominator with M=255. A design that forgot the +1 would fall one strobe short in every N-cycle window.
- Rewriting the same value in the middle of a run. A design that kept its accumulator across writes would place later strobes off the expected positions.

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 8,
  localparam int CFG_W = NUM_W + DEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             strobe
);

  logic [CFG_W-1:0] cfg_q;
  logic [NUM_W-1:0] acc;
  logic             strobe_q;
  logic [NUM_W-1:0] num;
  logic [DEN_W:0]   den;
  logic [NUM_W:0]   sum;
  logic [NUM_W:0]   num_x;
  logic             valid;
  logic             hit;

  assign num   = cfg_q[CFG_W-1:DEN_W];
  assign den   = (DEN_W+1)'(cfg_q[DEN_W-1:0]) + (DEN_W+1)'(1);
  assign num_x = {1'b0, num};
  assign sum   = {1'b0, acc} + (NUM_W+1)'(den);
  assign valid = (num != '0) && (num_x >= (NUM_W+1)'(den));
  assign hit   = valid && (sum >= num_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      acc      <= '0;
      strobe_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q    <= cfg_wdata;
      acc      <= '0;
      strobe_q <= 1'b0;
    end else if (!valid) begin
      acc      <= '0;
      strobe_q <= 1'b0;
    end else if (hit) begin
      acc      <= NUM_W'(sum - num_x);
      strobe_q <= 1'b1;
    end else begin
      acc      <= sum[NUM_W-1:0];
      strobe_q <= 1'b0;
    end
  end

  assign cfg_rdata = cfg_q;
  assign strobe    = strobe_q;

  a_r5_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !strobe);

  a_r6_zero_num_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && num == '0) |=> !strobe);

  a_r7_small_num_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && num_x < (NUM_W+1)'(den)) |=> !strobe);

  a_r8_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && num_x == (NUM_W+1)'(den)) |=> strobe);

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && strobe && valid && ((NUM_W+2)'(den) * 2 <= (NUM_W+2)'(num))) |=> !strobe);

  a_r3_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (acc < num));

endmodule

// File: tb/frac_strobe_gen_test.sv
module frac_strobe_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        strobe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  frac_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .strobe(strobe)
  );

  // {N[23:0], M[7:0], run length[23:0]}
  localparam logic [55:0] VEC [7] = '{
    {24'd7,    8'd2,   24'd21},
    {24'd10,   8'd3,   24'd30},
    {24'd5,    8'd4,   24'd10},
    {24'd4,    8'd4,   24'd12},
    {24'd0,    8'd0,   24'd8},
    {24'd300,  8'd255, 24'd600},
    {24'd1000, 8'd2,   24'd1000}
  };

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model(input longint n, input longint d, input longint j);
    if (n == 0 || n < d) return 1'b0;
    return ((j * d) / n) != (((j - 1) * d) / n);
  endfunction

  task automatic write_cfg(input logic [23:0] n, input logic [7:0] m);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {n, m};
    @(negedge clk);
    cfg_wr = 1'b0;
    check(strobe == 1'b0, "R5 strobe low after write", strobe, 0);
    check(cfg_rdata == {n, m}, "R2 readback", cfg_rdata, {n, m});
  endtask

  task automatic run_and_check(input longint n, input longint m, input longint len, input longint j0);
    longint d = m + 1;
    int win1 = 0;
    int win2 = 0;
    for (longint j = j0; j < j0 + len; j++) begin
      bit e = model(n, d, j);
      if (j > j0) @(negedge clk);
      if (n == 0)
        check(strobe == 1'b0, "R6 zero N idle", strobe, 0);
      else if (n < d)
        check(strobe == 1'b0, "R7 small N idle", strobe, 0);
      else if (n == d)
        check(strobe == 1'b1, "R8 full rate", strobe, 1);
      else
        check(strobe == e, "R3 strobe position", strobe, e);
      if (j <= n) win1 += int'(strobe);
      else if (j <= 2 * n) win2 += int'(strobe);
    end
    if (n != 0 && n >= d && j0 == 1) begin
      if (len >= n) check(win1 == d, "R4 first window count", win1, d);
      if (len >= 2 * n) check(win2 == d, "R4 second window count", win2, d);
    end
  endtask

  initial begin
    #2ms;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(strobe == 1'b0, "R1 reset strobe", strobe, 0);
    check(cfg_rdata == 32'd0, "R1 reset readback", cfg_rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(strobe == 1'b0, "R1 idle after reset", strobe, 0);

    foreach (VEC[i]) begin
      write_cfg(VEC[i][55:32], VEC[i][31:24]);
      @(negedge clk);
      run_and_check(longint'(VEC[i][55:32]), longint'(VEC[i][31:24]), longint'(VEC[i][23:0]), 1);
    end

    // R9: sparse ratio never strobes twice in a row
    write_cfg(24'd9, 8'd3);
    begin
      int back = 0;
      logic prev = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (prev && strobe) back++;
        prev = strobe;
      end
      check(back == 0, "R9 no back-to-back strobes", back, 0);
    end

    // R5: rewriting the same value mid-run restarts the sequence
    write_cfg(24'd7, 8'd2);
    repeat (4) @(negedge clk);
    write_cfg(24'd7, 8'd2);
    @(negedge clk);
    run_and_check(7, 2, 14, 1);

    // R5: changing value mid-run, then a fresh run
    write_cfg(24'd11, 8'd4);
    repeat (3) @(negedge clk);
    write_cfg(24'd13, 8'd4);
    @(negedge clk);
    run_and_check(13, 4, 26, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule